// File: doc/BRIEF.md
# Double-Rate Two-Word Burst SRAM Model

This block is a synthesizable, cycle-accurate model of a synchronous SRAM with a shared bidirectional data port. Every access moves a burst of two words. The address and the command pins run at single rate. Data moves on both clock edges. The rising edge of `clk` stands for the primary clock K. The falling edge of `clk` stands for its complement K#. Only one clock pair is modelled (single-clock operation). Output data is launched from the same clock that captures commands.

Each row of the internal array holds both words of a burst side by side. Address bit 0 picks which half of the row the burst starts in, and the burst then wraps inside that row. Writes merge into the row lane by lane under active-low byte masks. A read issued directly behind a write to the same row sees the new data through a forwarding path. A write request in the cycle after an accepted read is dropped, which keeps the write data off the bus while read data is on it. The port drives `dq` only while read words are being presented.

Top module: `ddr2b_sram`

## Requirements
- R1: On a rising clock edge with `ld_n` low and `rw` high, a read of the row `addr[ADDR_W-1:1]` is accepted. Its first word is on `dq` during the high phase one clock after the command. Its second word is on `dq` during the low phase that follows.
- R2: On a rising clock edge with `ld_n` low and `rw` low, a write is accepted unless R7 applies. The first data word and its masks are taken at the next rising edge. The second word and its masks are taken at the falling edge after that.
- R3: With `ld_n` high on a rising edge, the values of `rw`, `addr`, `bw_n` and `dq` start nothing. Operations already accepted still complete.
- R4: Address bit 0 sets the burst order. With 0, the first word goes to half 0 and the second to half 1. With 1, the first word goes to half 1 and the second wraps to half 0. A read returns the two halves in the same order for its own bit 0. The upper address bits never change within a burst.
- R5: `bw_n` is active low, with one bit per 9-bit lane: bit i covers `dq[9i+8:9i]`, so the default 36-bit word has four lanes. Each mask bit applies to the data word sampled on the same edge. A lane whose mask bit is high keeps its old contents.
- R6: A read accepted on the rising edge right after a write to the same row returns the row as updated by that write.
- R7: A write request (`ld_n` low, `rw` low) on the rising edge right after an accepted read is a no-operation. No data is taken and the memory is unchanged.
- R8: `dq_oe` is high, and `dq` is driven, exactly during the two half-cycles that carry read words. At all other times, including during and right after reset, `dq_oe` is low and `dq` is high impedance. All rows read as zero after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; rising edge is K, falling edge is K# |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_n | input | 1 | Active-low load: starts an operation |
| rw | input | 1 | 1 = read, 0 = write; used only when `ld_n` is low |
| addr | input | ADDR_W | Bit 0 = burst start half, upper bits = row |
| bw_n | input | WORD_W/9 | Active-low lane write masks, one per 9-bit lane |
| dq | inout | WORD_W | Shared data bus |
| dq_oe | output | 1 | High while the block drives `dq` |

## Verification
The hardest case to reach from the ports is forwarding. A read must be issued on the very edge after a write to the same row. At that point the write's second word has only just been captured on the falling edge, and the row in the array is still stale. The directed part of the bench sets up this case on purpose, with partial masks and a wrapped start, so that the forwarded merge is visible lane by lane. The random part then confines addresses to eight rows, which makes write-then-read collisions and write-after-read drops occur often. A reference array in the bench updates only for writes the bench itself judges as accepted.

// File: rtl/ddr2b_pkg.sv
package ddr2b_pkg;
  localparam int LANE_W = 9;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;
endpackage

// File: rtl/ddr2b_ctrl.sv
module ddr2b_ctrl
  import ddr2b_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_n,
  input  logic              rw,
  input  logic [ADDR_W-1:0] addr,
  output logic              rd_acc,
  output logic              wr_acc,
  output logic [ADDR_W-1:0] acc_addr,
  output logic              commit_en,
  output logic [ADDR_W-1:0] commit_addr,
  output logic              wr_dropped
);
  op_e op_d;

  // decode of the command pins; a write right behind a read is turned away
  always_comb begin
    if (ld_n)        op_d = OP_IDLE;
    else if (rw)     op_d = OP_READ;
    else if (rd_acc) op_d = OP_IDLE;
    else             op_d = OP_WRITE;
  end

  assign wr_dropped = !ld_n && !rw && rd_acc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_acc      <= 1'b0;
      wr_acc      <= 1'b0;
      acc_addr    <= '0;
      commit_en   <= 1'b0;
      commit_addr <= '0;
    end else begin
      rd_acc      <= (op_d == OP_READ);
      wr_acc      <= (op_d == OP_WRITE);
      if (!ld_n) acc_addr <= addr;
      commit_en   <= wr_acc;
      commit_addr <= acc_addr;
    end
  end
endmodule

// File: rtl/ddr2b_wcap.sv
module ddr2b_wcap #(
  parameter int WORD_W = 36,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_first,
  input  logic              cap_second,
  input  logic [WORD_W-1:0] dq_in,
  input  logic [LANES-1:0]  bw_n,
  output logic [WORD_W-1:0] word_a,
  output logic [LANES-1:0]  en_a,
  output logic [WORD_W-1:0] word_b,
  output logic [LANES-1:0]  en_b
);
  // first word of a burst, taken on the rising edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_a <= '0;
      en_a   <= '0;
    end else if (cap_first) begin
      word_a <= dq_in;
      en_a   <= ~bw_n;
    end
  end

  // second word, taken on the falling edge that follows
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_b <= '0;
      en_b   <= '0;
    end else if (cap_second) begin
      word_b <= dq_in;
      en_b   <= ~bw_n;
    end
  end
endmodule

// File: rtl/ddr2b_array.sv
module ddr2b_array
  import ddr2b_pkg::*;
#(
  parameter int WORD_W = 36,
  parameter int ADDR_W = 6,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit_en,
  input  logic [ADDR_W-1:0] commit_addr,
  input  logic [WORD_W-1:0] word_a,
  input  logic [LANES-1:0]  en_a,
  input  logic [WORD_W-1:0] word_b,
  input  logic [LANES-1:0]  en_b,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WORD_W-1:0] rd_first,
  output logic [WORD_W-1:0] rd_second,
  output logic              fwd_hit
);
  localparam int ROW_W = ADDR_W - 1;
  localparam int ROWS  = 1 << ROW_W;
  localparam int ENT_W = 2 * WORD_W;

  logic [ENT_W-1:0] mem [ROWS];
  logic [WORD_W-1:0] bits_a, bits_b;

  // one 9-bit field of enables per lane
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign bits_a[g*LANE_W +: LANE_W] = {LANE_W{en_a[g]}};
    assign bits_b[g*LANE_W +: LANE_W] = {LANE_W{en_b[g]}};
  end

  function automatic logic [ENT_W-1:0] place_burst(
    input logic [ENT_W-1:0]  old_row,
    input logic              start,
    input logic [WORD_W-1:0] a, ma,
    input logic [WORD_W-1:0] b, mb
  );
    logic [WORD_W-1:0] lo, hi;
    lo = old_row[WORD_W-1:0];
    hi = old_row[ENT_W-1:WORD_W];
    if (start) begin
      hi = (hi & ~ma) | (a & ma);
      lo = (lo & ~mb) | (b & mb);
    end else begin
      lo = (lo & ~ma) | (a & ma);
      hi = (hi & ~mb) | (b & mb);
    end
    return {hi, lo};
  endfunction

  logic [ROW_W-1:0] wr_row, rd_row;
  logic [ENT_W-1:0] merged, rd_row_data;

  assign wr_row  = commit_addr[ADDR_W-1:1];
  assign rd_row  = rd_addr[ADDR_W-1:1];
  assign merged  = place_burst(mem[wr_row], commit_addr[0], word_a, bits_a, word_b, bits_b);
  assign fwd_hit = commit_en && (wr_row == rd_row);

  assign rd_row_data = fwd_hit ? merged : mem[rd_row];
  assign rd_first    = rd_addr[0] ? rd_row_data[ENT_W-1:WORD_W] : rd_row_data[WORD_W-1:0];
  assign rd_second   = rd_addr[0] ? rd_row_data[WORD_W-1:0]     : rd_row_data[ENT_W-1:WORD_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < ROWS; r++) mem[r] <= '0;
    end else if (commit_en) begin
      mem[wr_row] <= merged;
    end
  end
endmodule

// File: rtl/ddr2b_rdout.sv
module ddr2b_rdout #(
  parameter int WORD_W = 36
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  logic [WORD_W-1:0] first,
  input  logic [WORD_W-1:0] second,
  output logic [WORD_W-1:0] dq_out,
  output logic              dq_oe,
  output logic              oe_launch
);
  logic [WORD_W-1:0] word_p, hold_q, word_n;
  logic              oe_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_launch <= 1'b0;
      word_p    <= '0;
      hold_q    <= '0;
    end else begin
      oe_launch <= launch;
      word_p    <= first;
      hold_q    <= second;
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_n   <= 1'b0;
      word_n <= '0;
    end else begin
      oe_n   <= oe_launch;
      word_n <= hold_q;
    end
  end

  // high phase shows the rising-edge register, low phase the falling-edge one
  assign dq_out = clk ? word_p : word_n;
  assign dq_oe  = clk ? oe_launch : oe_n;
endmodule

// File: rtl/ddr2b_sram.sv
module ddr2b_sram
  import ddr2b_pkg::*;
#(
  parameter int WORD_W = 36,
  parameter int ADDR_W = 6
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      ld_n,
  input  logic                      rw,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [WORD_W/LANE_W-1:0]  bw_n,
  inout  wire  [WORD_W-1:0]         dq,
  output logic                      dq_oe
);
  localparam int LANES = WORD_W / LANE_W;

  logic              rd_acc, wr_acc, commit_en, wr_dropped, fwd_hit, oe_launch;
  logic [ADDR_W-1:0] acc_addr, commit_addr;
  logic [WORD_W-1:0] word_a, word_b, rd_first, rd_second, dq_out, dq_in;
  logic [LANES-1:0]  en_a, en_b;

  assign dq_in = dq;
  assign dq    = dq_oe ? dq_out : {WORD_W{1'bz}};

  ddr2b_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .ld_n(ld_n), .rw(rw), .addr(addr),
    .rd_acc(rd_acc), .wr_acc(wr_acc), .acc_addr(acc_addr),
    .commit_en(commit_en), .commit_addr(commit_addr), .wr_dropped(wr_dropped)
  );

  ddr2b_wcap #(.WORD_W(WORD_W), .LANES(LANES)) u_wcap (
    .clk(clk), .rst_n(rst_n), .cap_first(wr_acc), .cap_second(commit_en),
    .dq_in(dq_in), .bw_n(bw_n),
    .word_a(word_a), .en_a(en_a), .word_b(word_b), .en_b(en_b)
  );

  ddr2b_array #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .LANES(LANES)) u_array (
    .clk(clk), .rst_n(rst_n), .commit_en(commit_en), .commit_addr(commit_addr),
    .word_a(word_a), .en_a(en_a), .word_b(word_b), .en_b(en_b),
    .rd_addr(acc_addr), .rd_first(rd_first), .rd_second(rd_second), .fwd_hit(fwd_hit)
  );

  ddr2b_rdout #(.WORD_W(WORD_W)) u_rdout (
    .clk(clk), .rst_n(rst_n), .launch(rd_acc), .first(rd_first), .second(rd_second),
    .dq_out(dq_out), .dq_oe(dq_oe), .oe_launch(oe_launch)
  );
endmodule

// File: rtl/ddr2b_sram_chk.sv
module ddr2b_sram_chk (
  input logic clk,
  input logic rst_n,
  input logic ld_n,
  input logic rd_acc,
  input logic wr_acc,
  input logic commit_en,
  input logic oe_launch
);
  // R7
  nop_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_acc |=> !wr_acc);

  // R3
  ld_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_n |=> !(rd_acc || wr_acc));

  // R2
  write_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_acc |=> commit_en);

  // R1
  read_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_acc |=> oe_launch);

  // R8
  oe_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    oe_launch |-> $past(rd_acc));
endmodule

bind ddr2b_sram ddr2b_sram_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ld_n(ld_n), .rd_acc(rd_acc),
  .wr_acc(wr_acc), .commit_en(commit_en), .oe_launch(oe_launch)
);

// File: tb/ddr2b_sram_tb.sv
module ddr2b_sram_tb;
  localparam int W    = 36;
  localparam int L    = W / 9;
  localparam int AW   = 6;
  localparam int ROWS = 1 << (AW - 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic          ld_n = 1'b1;
  logic          rw = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [L-1:0]  bw_n = '1;
  logic [W-1:0]  tb_dq = '0;
  logic          tb_drv = 1'b0;
  wire  [W-1:0]  dq;
  wire           dq_oe;

  assign dq = tb_drv ? tb_dq : {W{1'bz}};

  ddr2b_sram #(.WORD_W(W), .ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .ld_n(ld_n), .rw(rw), .addr(addr),
    .bw_n(bw_n), .dq(dq), .dq_oe(dq_oe)
  );

  logic [2*W-1:0] ref_mem [ROWS];
  int  checks = 0;
  int  errors = 0;
  bit  done = 0;
  string tag = "R1";

  // command at the last edge (cur) and the one before (prev)
  bit           cur_rd, cur_wr, prev_rd, prev_wr;
  logic [W-1:0] cur_a, cur_b, prev_b, cur_e1, cur_e2, prev_e1, prev_e2;
  logic [L-1:0] cur_ma, cur_mb, prev_mb;

  // reference row update: slots w[0], w[1]; first word at slot s, second at the other
  function automatic logic [2*W-1:0] ref_write(logic [2*W-1:0] old, bit s,
      logic [W-1:0] a, logic [L-1:0] ma_n, logic [W-1:0] b, logic [L-1:0] mb_n);
    logic [W-1:0] w [2];
    w[0] = old[W-1:0];
    w[1] = old[2*W-1:W];
    for (int i = 0; i < L; i++) begin
      if (!ma_n[i]) w[s][i*9 +: 9]  = a[i*9 +: 9];
      if (!mb_n[i]) w[!s][i*9 +: 9] = b[i*9 +: 9];
    end
    return {w[1], w[0]};
  endfunction

  function automatic logic [W-1:0] ref_word(logic [2*W-1:0] row, bit slot);
    return slot ? row[2*W-1:W] : row[W-1:0];
  endfunction

  task automatic chk_w(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: dq actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_b(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: dq_oe actual %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  // entered 1 ns after a rising edge; returns 1 ns after the next rising edge
  task automatic tick(bit ld, bit rwi, logic [AW-1:0] a, logic [W-1:0] da,
                      logic [W-1:0] db, logic [L-1:0] ma, logic [L-1:0] mb);
    bit n_rd, n_wr;
    logic [W-1:0] n_e1, n_e2;
    // high phase: first read word of a read issued two edges back
    if (prev_rd) begin
      chk_b("R8", dq_oe, 1'b1);
      chk_w(tag, dq, prev_e1);
    end else begin
      chk_b("R8", dq_oe, 1'b0);
    end
    if (prev_wr) begin
      tb_dq = prev_b; bw_n = prev_mb; tb_drv = 1'b1;
    end else begin
      tb_drv = 1'b0; bw_n = '1;
    end
    ld_n = ld; rw = rwi; addr = a;
    n_rd = !ld && rwi;
    n_wr = !ld && !rwi && !cur_rd;   // R7: write right behind a read is dropped
    n_e1 = '0; n_e2 = '0;
    if (n_wr) ref_mem[a[AW-1:1]] = ref_write(ref_mem[a[AW-1:1]], a[0], da, ma, db, mb);
    if (n_rd) begin
      n_e1 = ref_word(ref_mem[a[AW-1:1]], a[0]);
      n_e2 = ref_word(ref_mem[a[AW-1:1]], !a[0]);
    end
    @(negedge clk); #1;
    if (prev_rd) begin
      chk_b("R8", dq_oe, 1'b1);
      chk_w(tag, dq, prev_e2);
    end else begin
      chk_b("R8", dq_oe, 1'b0);
    end
    if (cur_wr) begin
      tb_dq = cur_a; bw_n = cur_ma; tb_drv = 1'b1;
    end else begin
      tb_drv = 1'b0; bw_n = '1;
    end
    @(posedge clk); #1;
    prev_rd = cur_rd; prev_wr = cur_wr; prev_b = cur_b; prev_mb = cur_mb;
    prev_e1 = cur_e1; prev_e2 = cur_e2;
    cur_rd = n_rd; cur_wr = n_wr; cur_a = da; cur_b = db; cur_ma = ma; cur_mb = mb;
    cur_e1 = n_e1; cur_e2 = n_e2;
  endtask

  task automatic rd(logic [AW-1:0] a);
    tick(1'b0, 1'b1, a, '0, '0, '1, '1);
  endtask
  task automatic wr(logic [AW-1:0] a, logic [W-1:0] da, logic [W-1:0] db,
                    logic [L-1:0] ma, logic [L-1:0] mb);
    tick(1'b0, 1'b0, a, da, db, ma, mb);
  endtask
  task automatic idle();
    tick(1'b1, 1'b0, '0, '0, '0, '1, '1);
  endtask

  function automatic logic [W-1:0] rnd_word();
    return W'({$urandom, $urandom});
  endfunction

  initial begin
    void'($urandom(32'd20260));
    for (int r = 0; r < ROWS; r++) ref_mem[r] = '0;
    cur_rd = 0; cur_wr = 0; prev_rd = 0; prev_wr = 0;
    cur_a = '0; cur_b = '0; prev_b = '0; cur_e1 = '0; cur_e2 = '0;
    prev_e1 = '0; prev_e2 = '0; cur_ma = '1; cur_mb = '1; prev_mb = '1;
    repeat (3) @(posedge clk);
    #1;
    chk_b("R8", dq_oe, 1'b0);          // R8: quiet during reset
    rst_n = 1'b1;
    @(posedge clk); #1;
    chk_b("R8", dq_oe, 1'b0);          // R8: quiet after reset

    // R8: an untouched row reads as zero
    tag = "R8";
    rd(6'd40); idle(); idle();

    // R2/R4: full write starting at half 0, then both read orders
    tag = "R2";
    wr(6'd8, 36'h1_2345_6789, 36'hA_BCDE_F012, 4'b0000, 4'b0000);
    idle();
    rd(6'd8);
    tag = "R4";
    rd(6'd9);
    // R7: write right behind a read is dropped, row keeps its content
    tag = "R7";
    wr(6'd8, 36'hF_FFFF_FFFF, 36'hF_FFFF_FFFF, 4'b0000, 4'b0000);
    idle();
    rd(6'd8);
    idle();

    // R4/R5/R6: wrapped partial write, then same-row read on the next edge
    tag = "R6";
    wr(6'd11, 36'h5_5555_5555, 36'h6_6666_6666, 4'b1010, 4'b0101);
    rd(6'd10);
    tag = "R5";
    rd(6'd11);
    idle();

    // R3: ld_n high with write-looking pins does nothing, then read back
    tag = "R3";
    tick(1'b1, 1'b0, 6'd10, 36'h0_0000_0000, 36'h0_0000_0000, 4'b0000, 4'b0000);
    tick(1'b1, 1'b1, 6'd8, '0, '0, '0, '0);
    rd(6'd10);
    idle();

    // back-to-back writes to one row then a read of it
    tag = "R6";
    wr(6'd12, 36'h1_1111_1111, 36'h2_2222_2222, 4'b0000, 4'b0000);
    wr(6'd13, 36'h3_3333_3333, 36'h4_4444_4444, 4'b1100, 4'b0011);
    rd(6'd12);
    idle();

    // random mix over eight rows
    tag = "R1";
    for (int n = 0; n < 600; n++) begin
      bit ld_r, rw_r;
      ld_r = ($urandom % 4) == 0;
      rw_r = $urandom % 2;
      tick(ld_r, rw_r, AW'($urandom % 16), rnd_word(), rnd_word(),
           L'($urandom), L'($urandom));
    end
    idle(); idle(); idle();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 20000);
    if (!done) begin
      errors++;
      $display("FAIL R1: watchdog actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule